// File: doc/BRIEF.md
# Synchronized Conversion Role Resolver

Two converter modules can share one synchronized conversion. Each side runs this resolver. The resolver takes the channel number sent by the partner over the synchronization link and the channel held in its own arbitration-result register. It also takes both modules' master requests and both modules' end-of-conversion pulses. From these it decides whether the local module leads the conversion, follows it, or does both.

The dual-master case applies when both modules ask for mastership in the same cycle and both have a synchronized request open. In that case an unsigned comparison of the two channel numbers assigns the role.

- A smaller partner channel makes the local side master, and its open request is withdrawn.
- A larger partner channel makes it slave, and the request stays open.
- An equal channel selects a combined master/slave mode. This mode freezes the arbitration-result register until the conversion completes.

The two modules may have different sample and conversion timing, so their finish pulses can arrive in any order and with any gap between them. The resolver remembers each pulse until it has seen both. It then runs a two-step completion:

1. An injection stage is held for one cycle.
2. A sticky done flag is set, the role is released, and an enabled single-cycle service request is raised.

Top module: `sync_role_resolver`

## Requirements
- R1: After reset, the following are all zero: `role` (encoding 0 none, 1 master, 2 slave, 3 master/slave), `sync_pend`, `ms_active`, `sync_done`, `srq`, `inj_busy` and `arb_ch`.
- R2: A role is assigned only in a cycle where all of these hold:
  - `loc_mreq`, `par_mreq` and `par_sreq` are all high.
  - `sync_pend` is set.
  - `role` is 0.
  Otherwise `role` remains 0.
- R3: When the conditions of R2 hold and `par_ch < arb_ch`, `role` becomes 1 on the next cycle and `sync_pend` is cleared.
- R4: When the conditions of R2 hold and `par_ch == arb_ch`, `role` becomes 3 and `ms_active` is set on the next cycle, and `sync_pend` stays set.
- R5: When the conditions of R2 hold and `par_ch > arb_ch`, `role` becomes 2 on the next cycle and `sync_pend` stays set.
- R6: An `arb_wr` pulse loads `arb_wr_ch` into `arb_ch` on the next cycle. It is ignored while `ms_active` is high.
- R7: While a role is held, `loc_done` and `par_done` pulses are each remembered. The cycle after both have been seen, in either order or together, `inj_busy` is high for exactly one cycle.
- R8: The cycle after `inj_busy`, all of the following happen:
  - `sync_done` is set.
  - `role` returns to 0.
  - `ms_active` clears.
  - `srq` pulses for one cycle if `srq_en` was high.
- R9: `sync_done` stays set until a `done_clr` pulse. A set and a clear in the same cycle leave it set.
- R10: Finish pulses that arrive while `role` is 0 are discarded and do not count toward a later completion.
- R11: Once assigned, `role` is held until completion, regardless of further master requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_set | input | 1 | Opens a local synchronized request |
| loc_mreq | input | 1 | Local module requests mastership |
| par_mreq | input | 1 | Partner requests mastership |
| par_sreq | input | 1 | Partner has a synchronized request for `par_ch` |
| par_ch | input | CH_W | Channel number received from the partner |
| arb_wr | input | 1 | Write strobe for the arbitration-result register |
| arb_wr_ch | input | CH_W | Channel value to write |
| loc_done | input | 1 | Local conversion finished (pulse) |
| par_done | input | 1 | Partner conversion finished (pulse) |
| srq_en | input | 1 | Service request enable |
| done_clr | input | 1 | Write-one-to-clear for `sync_done` |
| arb_ch | output | CH_W | Arbitration-result channel |
| role | output | 2 | Resolved role |
| sync_pend | output | 1 | Open synchronized request |
| ms_active | output | 1 | Master/slave mode active, arbitration register locked |
| inj_busy | output | 1 | Injection stage of completion |
| sync_done | output | 1 | Sticky synchronized-conversion done flag |
| srq | output | 1 | Completion service request pulse |

## Verification
Each result has a fixed latency after the input edge that causes it:

- `role`, `sync_pend`, `ms_active` and `arb_ch` respond one cycle after the edge that samples the stimulus.
- `inj_busy` rises one cycle after the edge at which the second finish pulse is seen.
- `sync_done`, `srq` and the release of `role` and `ms_active` follow one cycle after that.
- `srq` falls again on the cycle after it rises.

The driver tags every expected value with the cycle in which it is due, counting from the edge that captures the stimulus. The monitor compares only at the falling edge of that cycle. Any expected value left unconsumed at the end is counted as a failure.

// File: rtl/sync_role_resolver.sv
module sync_role_resolver #(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sync_set,
  input  logic            loc_mreq,
  input  logic            par_mreq,
  input  logic            par_sreq,
  input  logic [CH_W-1:0] par_ch,
  input  logic            arb_wr,
  input  logic [CH_W-1:0] arb_wr_ch,
  input  logic            loc_done,
  input  logic            par_done,
  input  logic            srq_en,
  input  logic            done_clr,
  output logic [CH_W-1:0] arb_ch,
  output logic [1:0]      role,
  output logic            sync_pend,
  output logic            ms_active,
  output logic            inj_busy,
  output logic            sync_done,
  output logic            srq
);

  localparam logic [1:0] ROLE_NONE   = 2'd0;
  localparam logic [1:0] ROLE_MASTER = 2'd1;
  localparam logic [1:0] ROLE_SLAVE  = 2'd2;
  localparam logic [1:0] ROLE_BOTH   = 2'd3;

  logic       loc_seen, par_seen;
  logic       dual, armed, both_in, ch_lt, ch_eq;
  logic [1:0] new_role;

  assign ch_lt    = par_ch < arb_ch;
  assign ch_eq    = par_ch == arb_ch;
  assign dual     = loc_mreq & par_mreq & par_sreq & sync_pend & (role == ROLE_NONE);
  assign new_role = ch_lt ? ROLE_MASTER : (ch_eq ? ROLE_BOTH : ROLE_SLAVE);
  assign armed    = (role != ROLE_NONE) & ~inj_busy;
  assign both_in  = armed & (loc_seen | loc_done) & (par_seen | par_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role      <= ROLE_NONE;
      sync_pend <= 1'b0;
      ms_active <= 1'b0;
      loc_seen  <= 1'b0;
      par_seen  <= 1'b0;
      inj_busy  <= 1'b0;
      sync_done <= 1'b0;
      srq       <= 1'b0;
      arb_ch    <= '0;
    end else begin
      if (inj_busy)  role <= ROLE_NONE;
      else if (dual) role <= new_role;

      if (dual && ch_lt) sync_pend <= 1'b0;
      else if (sync_set) sync_pend <= 1'b1;

      if (inj_busy)           ms_active <= 1'b0;
      else if (dual && ch_eq) ms_active <= 1'b1;

      if (both_in) begin
        loc_seen <= 1'b0;
        par_seen <= 1'b0;
      end else begin
        if (armed && loc_done) loc_seen <= 1'b1;
        if (armed && par_done) par_seen <= 1'b1;
      end

      inj_busy <= both_in;
      srq      <= inj_busy & srq_en;

      if (inj_busy)      sync_done <= 1'b1;
      else if (done_clr) sync_done <= 1'b0;

      if (arb_wr && !ms_active) arb_ch <= arb_wr_ch;
    end
  end

endmodule

// File: rtl/sync_role_resolver_chk.sv
module sync_role_resolver_chk #(
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            done_clr,
  input logic [CH_W-1:0] arb_ch,
  input logic [1:0]      role,
  input logic            sync_pend,
  input logic            ms_active,
  input logic            inj_busy,
  input logic            sync_done,
  input logic            srq
);

  AST_MASTER_DROPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(role) == 2'd0 && role == 2'd1) |-> !sync_pend); // R3

  AST_MS_IMPLIES_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    ms_active |-> role == 2'd3); // R4

  AST_ARB_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ms_active |=> $stable(arb_ch)); // R6

  AST_INJ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    inj_busy |=> !inj_busy); // R7

  AST_INJ_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    inj_busy |=> (sync_done && role == 2'd0 && !ms_active)); // R8

  AST_SRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    srq |=> !srq); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_done && !done_clr) |=> sync_done); // R9

  AST_ROLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (role != 2'd0 && !inj_busy) |=> $stable(role)); // R11

endmodule

bind sync_role_resolver sync_role_resolver_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_clr(done_clr), .arb_ch(arb_ch),
  .role(role), .sync_pend(sync_pend), .ms_active(ms_active),
  .inj_busy(inj_busy), .sync_done(sync_done), .srq(srq)
);

// File: tb/sync_role_resolver_test.sv
module sync_role_resolver_test;
  localparam int CLK_PERIOD = 10;
  localparam int CH_W = 5;

  logic clk = 0, rst_n = 0;
  logic sync_set = 0, loc_mreq = 0, par_mreq = 0, par_sreq = 0;
  logic [CH_W-1:0] par_ch = '0, arb_wr_ch = '0, arb_ch;
  logic arb_wr = 0, loc_done = 0, par_done = 0, srq_en = 0, done_clr = 0;
  logic [1:0] role;
  logic sync_pend, ms_active, inj_busy, sync_done, srq;

  sync_role_resolver #(.CH_W(CH_W)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int cyc; int sig; int val; string req; } item_t;
  item_t sbq[$];
  int cyc = 0, checks = 0, fails = 0;
  string names [7] = '{"role","sync_pend","ms_active","sync_done","srq","inj_busy","arb_ch"};

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int peek(int s);
    case (s)
      0: return int'(role);
      1: return int'(sync_pend);
      2: return int'(ms_active);
      3: return int'(sync_done);
      4: return int'(srq);
      5: return int'(inj_busy);
      default: return int'(arb_ch);
    endcase
  endfunction

  task automatic expect_at(int d, int s, int v, string req);
    item_t it;
    it.cyc = cyc + d; it.sig = s; it.val = v; it.req = req;
    sbq.push_back(it);
  endtask

  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].cyc == cyc) begin
        checks++;
        if (peek(sbq[i].sig) != sbq[i].val) begin
          fails++;
          $display("FAIL %s: %s actual %0d expected %0d (cycle %0d)", sbq[i].req,
                   names[sbq[i].sig], peek(sbq[i].sig), sbq[i].val, cyc);
        end
        sbq.delete(i);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic setup(int ch);
    arb_wr = 1; arb_wr_ch = ch[CH_W-1:0]; sync_set = 1;
    expect_at(1, 6, ch, "R6");
    expect_at(1, 1, 1, "R2");
    step();
    arb_wr = 0; sync_set = 0;
  endtask

  task automatic resolve(int ch, bit pm);
    loc_mreq = 1; par_mreq = pm; par_sreq = 1; par_ch = ch[CH_W-1:0];
    step();
    loc_mreq = 0; par_mreq = 0; par_sreq = 0;
  endtask

  initial begin
    step(2);
    rst_n = 1;
    foreach (names[k]) expect_at(0, k, 0, "R1");
    step();
    // R2: no open request
    resolve(3, 1); expect_at(0, 0, 0, "R2");
    // R10: finish pulse while idle
    loc_done = 1; step(); loc_done = 0;
    setup(10);
    // R2: partner master request missing
    resolve(5, 0); expect_at(0, 0, 0, "R2");
    step();
    // R3: partner channel smaller
    expect_at(1, 0, 1, "R3"); expect_at(1, 1, 0, "R3");
    resolve(5, 1);
    // R6: write allowed outside master/slave mode
    arb_wr = 1; arb_wr_ch = 7; expect_at(1, 6, 7, "R6"); step(); arb_wr = 0;
    par_done = 1; step(); par_done = 0;
    expect_at(0, 5, 0, "R10"); expect_at(1, 5, 0, "R10");
    step(2);
    srq_en = 1;
    loc_done = 1;
    expect_at(1, 5, 1, "R7"); expect_at(2, 5, 0, "R7");
    expect_at(2, 3, 1, "R8"); expect_at(2, 4, 1, "R8");
    expect_at(2, 0, 0, "R8"); expect_at(3, 4, 0, "R8");
    step(); loc_done = 0;
    step(4);
    expect_at(0, 3, 1, "R9");
    done_clr = 1; expect_at(1, 3, 0, "R9"); step(); done_clr = 0;
    // R4: equal channels
    setup(12);
    expect_at(1, 0, 3, "R4"); expect_at(1, 2, 1, "R4"); expect_at(1, 1, 1, "R4");
    resolve(12, 1);
    arb_wr = 1; arb_wr_ch = 3; expect_at(1, 6, 12, "R6"); step(); arb_wr = 0;
    expect_at(1, 0, 3, "R11");
    resolve(1, 1);
    srq_en = 0;
    loc_done = 1; par_done = 1;
    expect_at(1, 5, 1, "R7"); expect_at(2, 2, 0, "R8");
    expect_at(3, 4, 0, "R8"); expect_at(2, 0, 0, "R8");
    step(); loc_done = 0; par_done = 0;
    done_clr = 1; expect_at(1, 3, 1, "R9");
    step(); done_clr = 0;
    expect_at(1, 3, 1, "R9");
    step(3);
    // R5: partner channel larger
    setup(4);
    expect_at(1, 0, 2, "R5"); expect_at(1, 1, 1, "R5");
    resolve(9, 1);
    par_done = 1; step(); par_done = 0;
    step(5);
    expect_at(0, 5, 0, "R7");
    loc_done = 1; srq_en = 1;
    expect_at(1, 5, 1, "R7"); expect_at(2, 4, 1, "R8"); expect_at(2, 0, 0, "R8");
    step(); loc_done = 0;
    step(6);
    if (sbq.size() != 0) begin
      fails += sbq.size();
      $display("FAIL R1: actual %0d pending expected 0", sbq.size());
    end
    summary();
  end
endmodule